// File: doc/BRIEF.md
# SPI Serial EEPROM Command Slave

This block is the digital front end of a byte-wide nonvolatile memory reached over a four-wire serial bus in clock modes 0 and 3. The bus pins (chip select, serial clock, data in, hold) are sampled by the system clock and turned into edge strobes. Input bits are taken on rising serial clock edges. Output bits move on falling edges. A command engine decodes a one-byte opcode, then collects a 16-bit address, data bytes or a status byte as the opcode requires.

Reads stream bytes from the array, and the address counter wraps from the top address to zero. Writes gather up to one page of bytes in a page buffer, wrapping on the low address bits inside the page. When chip select rises on a byte boundary, the buffer is copied into the array and a self-timed program cycle begins. While that cycle runs, only the status read is executed. The array is a small register model whose contents after reset are a computed pattern.

The engine states are IDLE (no frame), OPCODE (first byte), ADDRESS (two address bytes), READ_DATA (streaming array bytes), WRITE_DATA (filling the page buffer), STATUS_READ (streaming the status byte), STATUS_WRITE (taking the new status byte), DONE (one-byte command finished, rest of frame unused) and SKIP (frame rejected). The transitions are:
- A chip select fall moves the engine to OPCODE, and a chip select rise returns it to IDLE from any state.
- From OPCODE, the engine goes to ADDRESS on read or enabled write, to STATUS_READ or STATUS_WRITE on the status opcodes, to DONE on enable or disable, and to SKIP on anything else.
- From ADDRESS, after the second byte, the engine goes to READ_DATA or WRITE_DATA.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset, no instruction is accepted until chip select has been seen high and then falls. An opcode clocked with chip select held low since reset does not enable the data output.
- R2: Opcode 0x06 sets the write-enable flag and opcode 0x04 clears it. The status byte is {user[5:0], write_enable, busy}, with busy in bit 0 and write_enable in bit 1.
- R3: Opcode 0x05 returns the status byte, most significant bit first, repeated for as long as clocks continue, and is executed even while a program cycle runs.
- R4: Opcode 0x03 followed by a 16-bit address (high byte first) streams array bytes MSB first. Address bits at and above ADDR_W are ignored. Output bits change only after falling clock edges.
- R5: During a read, the address advances by one after each byte and wraps from 2^ADDR_W-1 to 0.
- R6: Opcode 0x02 is executed only with write-enable set. Each data byte advances only the low PAGE_W address bits, so bytes past the page end land at the start of the same page, and bytes outside that page are untouched.
- R7: A write or status write commits only if chip select rises after a whole number of data bytes, at least one. Otherwise nothing changes and write-enable keeps its value.
- R8: A commit starts a program cycle of WRITE_CYCLES clocks with busy set. During it every opcode except 0x05 is ignored. Busy and write-enable clear in the same cycle when it ends.
- R9: An opcode outside the six defined codes makes the block ignore the rest of the frame until chip select rises, with the data output disabled.
- R10: Hold taken low while the serial clock is low pauses the frame: the output is disabled and clock edges are ignored. Releasing hold with the clock low resumes exactly where the frame stopped.
- R11: Opcode 0x01 with write-enable set stores data bits 7:2 as the user status bits on commit and starts a program cycle. Without write-enable it has no effect.
- R12: The output enable is low whenever chip select is high or the current instruction is not returning data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| mosi | input | 1 | Serial data into the block |
| hold_n | input | 1 | Pause request, active low |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Drive enable for miso; low means high impedance |

## Verification
The end of a program cycle can land in the middle of a status read frame. When it does, the timer clearing busy and write-enable meets the engine reloading the status byte for the next output byte. The bench keeps one status read frame open across the whole cycle, and it checks that every byte it receives is either the coherent busy value (write-enable and busy both set) or the coherent idle value. It also checks that the sequence ends with the idle value and never shows a mixed byte.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_SREAD,
        ST_SWRITE,
        ST_DONE,
        ST_SKIP
    } cmd_state_t;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    // Model contents after reset: byte at address a is (3a+1) mod 256
    function automatic logic [7:0] preload_byte(input int unsigned a);
        logic [31:0] v;
        v = a * 3 + 1;
        return v[7:0];
    endfunction

endpackage

// File: rtl/spi_pin_front.sv
module spi_pin_front (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    input  logic hold_n,
    output logic sel,
    output logic sel_rise,
    output logic sel_fall,
    output logic clk_rise,
    output logic clk_fall,
    output logic din,
    output logic held
);

    logic cs_m, cs_s, cs_d;
    logic ck_m, ck_s, ck_d;
    logic d_m, d_s;
    logic h_m, h_s;
    logic held_q;

    // Chip select resets as "low" so only a seen-high-then-low gives a fall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_m   <= 1'b0;
            cs_s   <= 1'b0;
            cs_d   <= 1'b0;
            ck_m   <= 1'b0;
            ck_s   <= 1'b0;
            ck_d   <= 1'b0;
            d_m    <= 1'b0;
            d_s    <= 1'b0;
            h_m    <= 1'b1;
            h_s    <= 1'b1;
            held_q <= 1'b0;
        end else begin
            cs_m <= cs_n;
            cs_s <= cs_m;
            cs_d <= cs_s;
            ck_m <= sclk;
            ck_s <= ck_m;
            ck_d <= ck_s;
            d_m  <= mosi;
            d_s  <= d_m;
            h_m  <= hold_n;
            h_s  <= h_m;
            if (!held_q && !h_s && !ck_s) begin
                held_q <= 1'b1;
            end else if (held_q && h_s && !ck_s) begin
                held_q <= 1'b0;
            end
        end
    end

    always_comb begin
        sel      = ~cs_s;
        sel_rise = cs_s & ~cs_d;
        sel_fall = ~cs_s & cs_d;
        clk_rise = ck_s & ~ck_d & ~held_q & ~cs_s;
        clk_fall = ~ck_s & ck_d & ~held_q & ~cs_s;
        din      = d_s;
        held     = held_q;
    end

    // R10
    hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held_q) |-> !$past(ck_s));

endmodule

// File: rtl/page_buf.sv
module page_buf #(
    parameter int PAGE_W = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         we,
    input  logic [PAGE_W-1:0]            col,
    input  logic [7:0]                   wdata,
    output logic [(1<<PAGE_W)-1:0][7:0]  pdata,
    output logic [(1<<PAGE_W)-1:0]       pvalid
);

    localparam int PAGE = 1 << PAGE_W;

    logic [PAGE-1:0][7:0] data_q;
    logic [PAGE-1:0]      valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= '0;
        end else if (clr) begin
            valid_q <= '0;
        end else if (we) begin
            data_q[col]  <= wdata;
            valid_q[col] <= 1'b1;
        end
    end

    assign pdata  = data_q;
    assign pvalid = valid_q;

endmodule

// File: rtl/mem_array.sv
module mem_array #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [7:0]                   rd_data,
    input  logic                         commit,
    input  logic [ADDR_W-PAGE_W-1:0]     page_idx,
    input  logic [(1<<PAGE_W)-1:0][7:0]  pdata,
    input  logic [(1<<PAGE_W)-1:0]       pvalid
);

    import eeprom_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAGE  = 1 << PAGE_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= preload_byte(i);
            end
        end else if (commit) begin
            for (int i = 0; i < DEPTH; i++) begin
                if ((i / PAGE) == int'(page_idx) && pvalid[i % PAGE]) begin
                    mem_q[i] <= pdata[i % PAGE];
                end
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
    parameter int WRITE_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(WRITE_CYCLES - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);

endmodule

// File: rtl/cmd_engine.sv
module cmd_engine #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel,
    input  logic                       sel_rise,
    input  logic                       sel_fall,
    input  logic                       clk_rise,
    input  logic                       clk_fall,
    input  logic                       din,
    input  logic                       held,
    input  logic                       busy,
    input  logic                       done,
    input  logic [7:0]                 rd_data,
    output logic [ADDR_W-1:0]          rd_addr,
    output logic                       pb_clr,
    output logic                       pb_we,
    output logic [PAGE_W-1:0]          pb_col,
    output logic [7:0]                 pb_data,
    output logic                       page_commit,
    output logic [ADDR_W-PAGE_W-1:0]   page_idx,
    output logic                       prog_start,
    output logic                       miso,
    output logic                       miso_oe
);

    import eeprom_pkg::*;

    cmd_state_t        state_q, state_d;
    logic [2:0]        bitcnt_q;
    logic [7:0]        sh_q;
    logic [7:0]        addr_hi_q;
    logic              phase_q;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;
    logic [7:0]        out_q;
    logic              fresh_q;
    logic              wel_q;
    logic [5:0]        user_q;
    logic [5:0]        wstat_q;
    logic              got_q;
    logic              prog_start_q;
    logic              page_commit_q;

    logic              byte_done;
    logic [7:0]        rx_byte;
    logic [ADDR_W-1:0] addr_new;
    logic [7:0]        status_now;

    always_comb begin
        byte_done  = clk_rise && (bitcnt_q == 3'd7);
        rx_byte    = {sh_q[6:0], din};
        addr_new   = ADDR_W'({addr_hi_q, rx_byte});
        status_now = {user_q, wel_q, busy};
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (sel_rise) begin
            state_d = ST_IDLE;
        end else if (sel_fall) begin
            state_d = ST_OPC;
        end else if (byte_done) begin
            unique case (state_q)
                ST_OPC: begin
                    if (busy) begin
                        state_d = (rx_byte == OP_RDSR) ? ST_SREAD : ST_SKIP;
                    end else begin
                        case (rx_byte)
                            OP_WREN:  state_d = ST_DONE;
                            OP_WRDI:  state_d = ST_DONE;
                            OP_RDSR:  state_d = ST_SREAD;
                            OP_WRSR:  state_d = wel_q ? ST_SWRITE : ST_SKIP;
                            OP_READ:  state_d = ST_ADDR;
                            OP_WRITE: state_d = wel_q ? ST_ADDR : ST_SKIP;
                            default:  state_d = ST_SKIP;
                        endcase
                    end
                end
                ST_ADDR: begin
                    if (phase_q) begin
                        state_d = wr_q ? ST_WDATA : ST_RDATA;
                    end
                end
                ST_IDLE, ST_RDATA, ST_WDATA, ST_SREAD,
                ST_SWRITE, ST_DONE, ST_SKIP: state_d = state_q;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q      <= '0;
            sh_q          <= '0;
            addr_hi_q     <= '0;
            phase_q       <= 1'b0;
            addr_q        <= '0;
            wr_q          <= 1'b0;
            out_q         <= '0;
            fresh_q       <= 1'b0;
            wel_q         <= 1'b0;
            user_q        <= '0;
            wstat_q       <= '0;
            got_q         <= 1'b0;
            prog_start_q  <= 1'b0;
            page_commit_q <= 1'b0;
        end else begin
            prog_start_q  <= 1'b0;
            page_commit_q <= 1'b0;
            if (sel_rise) begin
                bitcnt_q <= '0;
                fresh_q  <= 1'b0;
                if (state_q == ST_WDATA && bitcnt_q == 3'd0 && got_q) begin
                    prog_start_q  <= 1'b1;
                    page_commit_q <= 1'b1;
                end
                if (state_q == ST_SWRITE && bitcnt_q == 3'd0 && got_q) begin
                    prog_start_q <= 1'b1;
                    user_q       <= wstat_q;
                end
            end else if (sel_fall) begin
                bitcnt_q <= '0;
                phase_q  <= 1'b0;
                got_q    <= 1'b0;
                fresh_q  <= 1'b0;
            end else begin
                if (clk_rise) begin
                    sh_q     <= rx_byte;
                    bitcnt_q <= bitcnt_q + 3'd1;
                end
                if (byte_done) begin
                    case (state_q)
                        ST_OPC: begin
                            if (rx_byte == OP_RDSR) begin
                                out_q   <= status_now;
                                fresh_q <= 1'b1;
                            end else if (!busy) begin
                                case (rx_byte)
                                    OP_WREN:  wel_q <= 1'b1;
                                    OP_WRDI:  wel_q <= 1'b0;
                                    OP_READ:  wr_q  <= 1'b0;
                                    OP_WRITE: wr_q  <= 1'b1;
                                    default:  ;
                                endcase
                            end
                        end
                        ST_ADDR: begin
                            if (!phase_q) begin
                                addr_hi_q <= rx_byte;
                                phase_q   <= 1'b1;
                            end else begin
                                addr_q <= addr_new;
                                if (!wr_q) begin
                                    out_q   <= rd_data;
                                    fresh_q <= 1'b1;
                                end
                            end
                        end
                        ST_WDATA: begin
                            addr_q <= {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
                            got_q  <= 1'b1;
                        end
                        ST_SWRITE: begin
                            wstat_q <= rx_byte[7:2];
                            got_q   <= 1'b1;
                        end
                        default: ;
                    endcase
                end
                if (clk_fall && (state_q == ST_RDATA || state_q == ST_SREAD)) begin
                    if (fresh_q) begin
                        fresh_q <= 1'b0;
                    end else if (bitcnt_q == 3'd0) begin
                        if (state_q == ST_RDATA) begin
                            addr_q <= addr_q + 1'b1;
                            out_q  <= rd_data;
                        end else begin
                            out_q <= status_now;
                        end
                    end else begin
                        out_q <= {out_q[6:0], 1'b0};
                    end
                end
            end
            if (done) begin
                wel_q <= 1'b0;
            end
        end
    end

    // Combinational datapath hooks
    always_comb begin
        rd_addr     = (state_q == ST_ADDR) ? addr_new : addr_q + 1'b1;
        pb_clr      = (state_q == ST_OPC) && byte_done && (rx_byte == OP_WRITE)
                      && !busy && wel_q;
        pb_we       = (state_q == ST_WDATA) && byte_done;
        pb_col      = addr_q[PAGE_W-1:0];
        pb_data     = rx_byte;
        page_commit = page_commit_q;
        page_idx    = addr_q[ADDR_W-1:PAGE_W];
        prog_start  = prog_start_q;
    end

    // Output process
    always_comb begin
        miso    = out_q[7];
        miso_oe = (state_q == ST_RDATA || state_q == ST_SREAD) && sel && !held;
    end

    // R8
    busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(state_q inside {ST_ADDR, ST_RDATA, ST_WDATA, ST_SWRITE}));

    // R8
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel_q);

    // R9
    skip_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP && !sel_rise) |=> state_q == ST_SKIP);

    // R12
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> !miso_oe);

    // R7
    commit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start_q |-> $past(bitcnt_q) == 3'd0);

endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
    parameter int ADDR_W       = 8,
    parameter int PAGE_W       = 6,
    parameter int WRITE_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    input  logic hold_n,
    output logic miso,
    output logic miso_oe
);

    localparam int PAGE  = 1 << PAGE_W;
    localparam int PIDX_W = ADDR_W - PAGE_W;

    logic sel, sel_rise, sel_fall, clk_rise, clk_fall, din, held;
    logic busy, done, prog_start;
    logic [ADDR_W-1:0]     rd_addr;
    logic [7:0]            rd_data;
    logic                  pb_clr, pb_we;
    logic [PAGE_W-1:0]     pb_col;
    logic [7:0]            pb_data;
    logic                  page_commit;
    logic [PIDX_W-1:0]     page_idx;
    logic [PAGE-1:0][7:0]  pdata;
    logic [PAGE-1:0]       pvalid;

    spi_pin_front front_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .mosi     (mosi),
        .hold_n   (hold_n),
        .sel      (sel),
        .sel_rise (sel_rise),
        .sel_fall (sel_fall),
        .clk_rise (clk_rise),
        .clk_fall (clk_fall),
        .din      (din),
        .held     (held)
    );

    cmd_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) engine_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .sel_rise    (sel_rise),
        .sel_fall    (sel_fall),
        .clk_rise    (clk_rise),
        .clk_fall    (clk_fall),
        .din         (din),
        .held        (held),
        .busy        (busy),
        .done        (done),
        .rd_data     (rd_data),
        .rd_addr     (rd_addr),
        .pb_clr      (pb_clr),
        .pb_we       (pb_we),
        .pb_col      (pb_col),
        .pb_data     (pb_data),
        .page_commit (page_commit),
        .page_idx    (page_idx),
        .prog_start  (prog_start),
        .miso        (miso),
        .miso_oe     (miso_oe)
    );

    page_buf #(.PAGE_W(PAGE_W)) pbuf_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (pb_clr),
        .we     (pb_we),
        .col    (pb_col),
        .wdata  (pb_data),
        .pdata  (pdata),
        .pvalid (pvalid)
    );

    mem_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) array_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .commit   (page_commit),
        .page_idx (page_idx),
        .pdata    (pdata),
        .pvalid   (pvalid)
    );

    prog_timer #(.WRITE_CYCLES(WRITE_CYCLES)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (prog_start),
        .busy  (busy),
        .done  (done)
    );

endmodule

// File: tb/spi_eeprom_slave_tb_top.sv
module spi_eeprom_slave_tb_top;

    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b0;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    logic hold_n = 1'b1;
    logic miso, miso_oe;

    int checks = 0;
    int failures = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] cap;
    event       rx_ev;

    always #10 clk = ~clk;

    spi_eeprom_slave dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .mosi    (mosi),
        .hold_n  (hold_n),
        .miso    (miso),
        .miso_oe (miso_oe)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 3 + 1) & 255);
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            mosi = tx[b];
            wait_clk(HALF);
            rx[b] = miso;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] junk;
        xfer(tx, junk);
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_hi();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    // Driver: queue the expected byte, clock it out, hand it to the monitor
    task automatic exp_byte(input logic [7:0] e, input string tag);
        logic [7:0] r;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        xfer(8'h00, r);
        cap = r;
        -> rx_ev;
        wait_clk(1);
    endtask

    // Monitor: pop and compare
    initial begin
        forever begin
            @(rx_ev);
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(cap == e, t, cap, e);
            end
        end
    end

    task automatic rd_status(input logic [7:0] e, input string tag);
        cs_lo();
        send(8'h05);
        exp_byte(e, tag);
        cs_hi();
    endtask

    task automatic one_op(input logic [7:0] op);
        cs_lo();
        send(op);
        cs_hi();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        bit seen;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);

        // R1: reset state, and no frame without a chip select fall
        chk(miso_oe == 1'b0, "R1 reset oe", {7'd0, miso_oe}, 8'h00);
        send(8'h05);
        wait_clk(2);
        chk(miso_oe == 1'b0, "R1 no fall", {7'd0, miso_oe}, 8'h00);
        cs_hi();
        chk(miso_oe == 1'b0, "R12 cs high", {7'd0, miso_oe}, 8'h00);

        // R2 / R3: status after reset, repeated bytes
        cs_lo();
        send(8'h05);
        chk(miso_oe == 1'b1, "R12 oe in status read", {7'd0, miso_oe}, 8'h01);
        exp_byte(8'h00, "R3 status first");
        exp_byte(8'h00, "R3 status repeat");
        cs_hi();
        chk(miso_oe == 1'b0, "R12 after deselect", {7'd0, miso_oe}, 8'h00);

        // R2: enable / disable
        cs_lo();
        send(8'h06);
        chk(miso_oe == 1'b0, "R12 non-data opcode", {7'd0, miso_oe}, 8'h00);
        cs_hi();
        rd_status(8'h02, "R2 enable sets bit1");
        one_op(8'h04);
        rd_status(8'h00, "R2 disable clears bit1");

        // R4 / R5: read with ignored upper bits
        cs_lo();
        send(8'h03); send(8'h12); send(8'h10);
        exp_byte(pat(16'h10), "R4 first byte");
        exp_byte(pat(16'h11), "R5 increment");
        exp_byte(pat(16'h12), "R5 increment");
        cs_hi();
        cs_lo();
        send(8'h03); send(8'h00); send(8'hFE);
        exp_byte(pat(8'hFE), "R4 near top");
        exp_byte(pat(8'hFF), "R5 top");
        exp_byte(pat(8'h00), "R5 rollover");
        exp_byte(pat(8'h01), "R5 after rollover");
        cs_hi();

        // R6: write without enable has no effect
        cs_lo();
        send(8'h02); send(8'h00); send(8'h20); send(8'h55);
        cs_hi();
        rd_status(8'h00, "R6 no cycle without enable");
        cs_lo();
        send(8'h03); send(8'h00); send(8'h20);
        exp_byte(pat(8'h20), "R6 unwritten");
        cs_hi();

        // R6 / R8: page write that wraps inside the page
        one_op(8'h06);
        cs_lo();
        send(8'h02); send(8'h00); send(8'h7E);
        send(8'h11); send(8'h22); send(8'h33);
        cs_hi();
        rd_status(8'h03, "R8 busy and enable");
        cs_lo();
        send(8'h03); send(8'h00); send(8'h40);
        wait_clk(2);
        chk(miso_oe == 1'b0, "R8 read ignored when busy", {7'd0, miso_oe}, 8'h00);
        cs_hi();
        one_op(8'h04);
        // Cycle end lands inside one long status frame
        cs_lo();
        send(8'h05);
        seen = 1'b0;
        for (int k = 0; k < 40 && !seen; k++) begin
            xfer(8'h00, r);
            chk(r == 8'h03 || r == 8'h00, "R8 coherent status", r, 8'h03);
            if (r == 8'h00) seen = 1'b1;
        end
        cs_hi();
        chk(seen, "R8 cycle ends", {7'd0, seen}, 8'h01);
        rd_status(8'h00, "R8 enable cleared at end");
        cs_lo();
        send(8'h03); send(8'h00); send(8'h7E);
        exp_byte(8'h11, "R6 byte at 7E");
        exp_byte(8'h22, "R6 byte at 7F");
        exp_byte(pat(8'h80), "R6 next page untouched");
        cs_hi();
        cs_lo();
        send(8'h03); send(8'h00); send(8'h40);
        exp_byte(8'h33, "R6 wrapped to page start");
        exp_byte(pat(8'h41), "R6 rest of page untouched");
        cs_hi();

        // R7: partial byte discards the write
        one_op(8'h06);
        cs_lo();
        send(8'h02); send(8'h00); send(8'h30); send(8'h99);
        for (int b = 0; b < 4; b++) begin
            mosi = 1'b1;
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        cs_hi();
        rd_status(8'h02, "R7 discarded, enable kept");
        cs_lo();
        send(8'h03); send(8'h00); send(8'h30);
        exp_byte(pat(8'h30), "R7 data unchanged");
        cs_hi();
        one_op(8'h04);

        // R9: unknown opcode ignores the rest of the frame
        cs_lo();
        send(8'hAB);
        send(8'h05);
        wait_clk(2);
        chk(miso_oe == 1'b0, "R9 rest ignored", {7'd0, miso_oe}, 8'h00);
        cs_hi();
        rd_status(8'h00, "R9 next frame normal");

        // R10: hold pause after address
        cs_lo();
        send(8'h03); send(8'h00); send(8'h05);
        hold_n = 1'b0;
        wait_clk(2 * HALF);
        chk(miso_oe == 1'b0, "R10 oe off in hold", {7'd0, miso_oe}, 8'h00);
        for (int t = 0; t < 3; t++) begin
            mosi = 1'b1;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
            wait_clk(HALF);
        end
        hold_n = 1'b1;
        wait_clk(2 * HALF);
        chk(miso_oe == 1'b1, "R10 oe back", {7'd0, miso_oe}, 8'h01);
        exp_byte(pat(8'h05), "R10 resumed byte");
        exp_byte(pat(8'h06), "R10 next byte");
        cs_hi();

        // R11: status write
        one_op(8'h06);
        cs_lo();
        send(8'h01); send(8'hFC);
        cs_hi();
        rd_status(8'hFF, "R11 busy during status write");
        cs_lo();
        send(8'h05);
        seen = 1'b0;
        for (int k = 0; k < 40 && !seen; k++) begin
            xfer(8'h00, r);
            if (r == 8'hFC) seen = 1'b1;
        end
        cs_hi();
        chk(seen, "R11 user bits stored", {7'd0, seen}, 8'h01);
        cs_lo();
        send(8'h01); send(8'h00);
        cs_hi();
        rd_status(8'hFC, "R11 ignored without enable");

        wait_clk(4);
        finish_run();
    end

endmodule